// File: doc/BRIEF.md
# Context-Banked Register File with Context-Carrying Program Counter

The block holds two register files, one for data and one for addresses. Each file has 64 entries, split into eight banks of eight. An instruction only ever names a register 0..7. The bank it lands in comes from a 3-bit execution-context register, so the physical entry is `{context, register}`. Switching context therefore gives a fresh set of eight registers per file with no copying. Each file has two combinational read ports and one write port. A read of the entry being written in the same cycle returns the new value.

The execution context is not a separate piece of state. It lives in bits 30:28 of the program counter, and bit 31 always reads as zero. When an exception sequencer saves the PC and later loads it back, the context is saved and restored with it.

Only 28 bits of the PC are left for the code offset. A code-segment register makes up the lost range: the 40-bit fetch address is the segment shifted left by 12 plus the 28-bit offset, truncated to 40 bits.

The PC update is a small per-cycle choice among five operations:
- `PC_LOAD`: a full PC load.
- `PC_STEP`: an offset advance.
- `CTX_SET`: a direct context change.
- `CTX_STEP`: a context change together with an advance.
- `PC_HOLD`: no change.

A load wins over everything else.

Top module: `ctx_regfile`

## Requirements
- R1: After reset, `pc_q`, `ctx_q`, `cseg_q` and `fetch_addr` are zero, and every register in both files reads as zero.
- R2: A register write goes to physical entry `{ctx_q, wr_idx}`. A value written under one context is seen only while that same context is active, and the same register index under another context keeps its own value.
- R3: The two read ports of a file are independent: each returns the entry selected by its own index in the active context.
- R4: When a file's write enable is high and a read index equals the write index, that read port returns the write data in the same cycle (combinational bypass).
- R5: The data and address files are separate: a write to one never changes any entry of the other.
- R6: `pc_q[31]` is always 0 and `pc_q[30:28]` always equals `ctx_q`.
- R7: `pc_load_en` loads the context from `pc_load_val[30:28]` and the offset from `pc_load_val[27:0]` at the next edge; `pc_load_val[31]` is ignored.
- R8: `pc_adv_en` adds `pc_adv_amt` to the 28-bit offset modulo 2^28. A wrap of the offset never carries into the context.
- R9: `ctx_set_en` replaces the context with `ctx_set_val` and leaves the offset alone, except that it may combine with an advance. `pc_load_en` has priority over both `ctx_set_en` and `pc_adv_en`.
- R10: `fetch_addr` equals `(cseg_q << 12) + pc_q[27:0]` modulo 2^40; the context bits do not enter the sum.
- R11: `cseg_wr_en` loads `cseg_q` from `cseg_wr_val` at the next edge; otherwise `cseg_q` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_wr_en | input | 1 | Data file write enable |
| d_wr_idx | input | 3 | Data file write register index |
| d_wr_data | input | 32 | Data file write value |
| d_rd_idx_a | input | 3 | Data file read port A index |
| d_rd_idx_b | input | 3 | Data file read port B index |
| d_rd_data_a | output | 32 | Data file read port A value |
| d_rd_data_b | output | 32 | Data file read port B value |
| a_wr_en | input | 1 | Address file write enable |
| a_wr_idx | input | 3 | Address file write register index |
| a_wr_data | input | 32 | Address file write value |
| a_rd_idx_a | input | 3 | Address file read port A index |
| a_rd_idx_b | input | 3 | Address file read port B index |
| a_rd_data_a | output | 32 | Address file read port A value |
| a_rd_data_b | output | 32 | Address file read port B value |
| pc_load_en | input | 1 | Load full PC (context and offset) |
| pc_load_val | input | 32 | PC value to load |
| pc_adv_en | input | 1 | Advance PC offset |
| pc_adv_amt | input | 4 | Byte amount to advance |
| ctx_set_en | input | 1 | Set execution context directly |
| ctx_set_val | input | 3 | New execution context |
| cseg_wr_en | input | 1 | Code segment write enable |
| cseg_wr_val | input | 28 | New code segment value |
| pc_q | output | 32 | Program counter with context in bits 30:28 |
| ctx_q | output | 3 | Active execution context |
| cseg_q | output | 28 | Code segment register |
| fetch_addr | output | 40 | 40-bit instruction fetch address |

## Verification
The assertions assume that control inputs are known and are only sampled at rising edges while `rst_n` is high. They also assume that any register writes made in the same cycle as a context change use the context that is active before that edge. The stimulus is applied on falling edges and holds steady across each rising edge. Multiple PC controls are raised together only in the cycles that test priority, so each assertion about a single operation sees that operation alone.

// File: rtl/ctxrf_pkg.sv
package ctxrf_pkg;
    // PC update operation chosen each cycle
    typedef enum logic [2:0] {
        PC_HOLD  = 3'd0,
        PC_LOAD  = 3'd1,
        PC_STEP  = 3'd2,
        CTX_SET  = 3'd3,
        CTX_STEP = 3'd4
    } pc_op_e;

    localparam int unsigned DEF_DATA_W    = 32;
    localparam int unsigned DEF_CTX_W     = 3;
    localparam int unsigned DEF_IDX_W     = 3;
    localparam int unsigned DEF_OFFS_W    = 28;
    localparam int unsigned DEF_CSEG_W    = 28;
    localparam int unsigned DEF_SEG_SHIFT = 12;
    localparam int unsigned DEF_FETCH_W   = 40;
    localparam int unsigned DEF_STEP_W    = 4;
endpackage

// File: rtl/ctxrf_bank.sv
module ctxrf_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CTX_W  = 3,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTX_W-1:0]  ctx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int unsigned PHYS_W  = CTX_W + IDX_W;
    localparam int unsigned ENTRIES = 1 << PHYS_W;
    localparam int unsigned NPORTS  = 2;

    logic [DATA_W-1:0] store_q [ENTRIES];
    logic [PHYS_W-1:0] wr_phys;
    logic [IDX_W-1:0]  port_idx  [NPORTS];
    logic [DATA_W-1:0] port_data [NPORTS];

    assign wr_phys     = {ctx, wr_idx};
    assign port_idx[0] = rd_idx_a;
    assign port_idx[1] = rd_idx_b;
    assign rd_data_a   = port_data[0];
    assign rd_data_b   = port_data[1];

    // One register per physical entry
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q[e] <= '0;
            end else if (wr_en && (wr_phys == PHYS_W'(e))) begin
                store_q[e] <= wr_data;
            end
        end
    end

    // Read ports with write-to-read bypass
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [PHYS_W-1:0] rd_phys;
        assign rd_phys = {ctx, port_idx[p]};
        always_comb begin
            if (wr_en && (rd_phys == wr_phys)) begin
                port_data[p] = wr_data;
            end else begin
                port_data[p] = store_q[rd_phys];
            end
        end
    end

    // R4: a read of the entry being written sees the new value
    a_r4_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rd_idx_a == wr_idx)) |-> (rd_data_a == wr_data));

    // R2: a written entry holds its value into the next cycle under the same context
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rd_idx_b == wr_idx)) ##1 ($stable(ctx) && $stable(rd_idx_b) && !wr_en)
        |-> (rd_data_b == $past(wr_data)));
endmodule

// File: rtl/ctxrf_pcctx.sv
module ctxrf_pcctx
    import ctxrf_pkg::*;
#(
    parameter int unsigned CTX_W  = 3,
    parameter int unsigned OFFS_W = 28,
    parameter int unsigned STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [CTX_W-1:0]  ld_ctx,
    input  logic [OFFS_W-1:0] ld_offs,
    input  logic              adv_en,
    input  logic [STEP_W-1:0] adv_amt,
    input  logic              cset_en,
    input  logic [CTX_W-1:0]  cset_val,
    output logic [CTX_W-1:0]  ctx_q,
    output logic [OFFS_W-1:0] offs_q
);
    pc_op_e            op;
    logic [CTX_W-1:0]  ctx_d;
    logic [OFFS_W-1:0] offs_d;
    logic [OFFS_W-1:0] offs_step;

    assign offs_step = offs_q + OFFS_W'(adv_amt);

    // Operation select: a full load dominates
    always_comb begin
        if (ld_en)                  op = PC_LOAD;
        else if (cset_en && adv_en) op = CTX_STEP;
        else if (cset_en)           op = CTX_SET;
        else if (adv_en)            op = PC_STEP;
        else                        op = PC_HOLD;
    end

    always_comb begin
        ctx_d  = ctx_q;
        offs_d = offs_q;
        unique case (op)
            PC_HOLD:  ;
            PC_LOAD: begin
                ctx_d  = ld_ctx;
                offs_d = ld_offs;
            end
            PC_STEP:  offs_d = offs_step;
            CTX_SET:  ctx_d  = cset_val;
            CTX_STEP: begin
                ctx_d  = cset_val;
                offs_d = offs_step;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q  <= '0;
            offs_q <= '0;
        end else begin
            ctx_q  <= ctx_d;
            offs_q <= offs_d;
        end
    end

    // R7: a load sets context and offset
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (ctx_q == $past(ld_ctx)) && (offs_q == $past(ld_offs)));

    // R8: an advance alone never touches the context
    a_r8_adv_keeps_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !ld_en && !cset_en) |=> $stable(ctx_q));

    // R9: a context set alone leaves the offset unchanged
    a_r9_cset_keeps_offs: assert property (@(posedge clk) disable iff (!rst_n)
        (cset_en && !ld_en && !adv_en) |=> ($stable(offs_q) && (ctx_q == $past(cset_val))));

    // R9: with no control raised, the PC holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !cset_en && !adv_en) |=> ($stable(offs_q) && $stable(ctx_q)));
endmodule

// File: rtl/ctxrf_fetch.sv
module ctxrf_fetch #(
    parameter int unsigned OFFS_W    = 28,
    parameter int unsigned CSEG_W    = 28,
    parameter int unsigned SEG_SHIFT = 12,
    parameter int unsigned FETCH_W   = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seg_wr_en,
    input  logic [CSEG_W-1:0]  seg_wr_val,
    input  logic [OFFS_W-1:0]  offs,
    output logic [CSEG_W-1:0]  seg_q,
    output logic [FETCH_W-1:0] fetch
);
    localparam int unsigned SUM_W = FETCH_W + 1;

    logic [SUM_W-1:0] base_ext;
    logic [SUM_W-1:0] offs_ext;
    logic [SUM_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (!rst_n)         seg_q <= '0;
        else if (seg_wr_en) seg_q <= seg_wr_val;
    end

    assign base_ext = SUM_W'(seg_q) << SEG_SHIFT;
    assign offs_ext = SUM_W'(offs);
    assign sum      = base_ext + offs_ext;
    assign fetch    = sum[FETCH_W-1:0];

    // R11: segment write lands on the next edge
    a_r11_seg_write: assert property (@(posedge clk) disable iff (!rst_n)
        seg_wr_en |=> (seg_q == $past(seg_wr_val)));

    // R11: segment holds without a write
    a_r11_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_wr_en |=> $stable(seg_q));
endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile
    import ctxrf_pkg::*;
#(
    parameter int unsigned DATA_W    = DEF_DATA_W,
    parameter int unsigned CTX_W     = DEF_CTX_W,
    parameter int unsigned IDX_W     = DEF_IDX_W,
    parameter int unsigned OFFS_W    = DEF_OFFS_W,
    parameter int unsigned CSEG_W    = DEF_CSEG_W,
    parameter int unsigned SEG_SHIFT = DEF_SEG_SHIFT,
    parameter int unsigned FETCH_W   = DEF_FETCH_W,
    parameter int unsigned STEP_W    = DEF_STEP_W,
    localparam int unsigned PC_W     = 1 + CTX_W + OFFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               d_wr_en,
    input  logic [IDX_W-1:0]   d_wr_idx,
    input  logic [DATA_W-1:0]  d_wr_data,
    input  logic [IDX_W-1:0]   d_rd_idx_a,
    input  logic [IDX_W-1:0]   d_rd_idx_b,
    output logic [DATA_W-1:0]  d_rd_data_a,
    output logic [DATA_W-1:0]  d_rd_data_b,
    input  logic               a_wr_en,
    input  logic [IDX_W-1:0]   a_wr_idx,
    input  logic [DATA_W-1:0]  a_wr_data,
    input  logic [IDX_W-1:0]   a_rd_idx_a,
    input  logic [IDX_W-1:0]   a_rd_idx_b,
    output logic [DATA_W-1:0]  a_rd_data_a,
    output logic [DATA_W-1:0]  a_rd_data_b,
    input  logic               pc_load_en,
    input  logic [PC_W-1:0]    pc_load_val,
    input  logic               pc_adv_en,
    input  logic [STEP_W-1:0]  pc_adv_amt,
    input  logic               ctx_set_en,
    input  logic [CTX_W-1:0]   ctx_set_val,
    input  logic               cseg_wr_en,
    input  logic [CSEG_W-1:0]  cseg_wr_val,
    output logic [PC_W-1:0]    pc_q,
    output logic [CTX_W-1:0]   ctx_q,
    output logic [CSEG_W-1:0]  cseg_q,
    output logic [FETCH_W-1:0] fetch_addr
);
    localparam int unsigned NFILES = 2;

    logic [OFFS_W-1:0] offs;
    logic              f_wr_en   [NFILES];
    logic [IDX_W-1:0]  f_wr_idx  [NFILES];
    logic [DATA_W-1:0] f_wr_data [NFILES];
    logic [IDX_W-1:0]  f_ra      [NFILES];
    logic [IDX_W-1:0]  f_rb      [NFILES];
    logic [DATA_W-1:0] f_da      [NFILES];
    logic [DATA_W-1:0] f_db      [NFILES];

    // file 0: data, file 1: address
    assign f_wr_en[0]   = d_wr_en;
    assign f_wr_idx[0]  = d_wr_idx;
    assign f_wr_data[0] = d_wr_data;
    assign f_ra[0]      = d_rd_idx_a;
    assign f_rb[0]      = d_rd_idx_b;
    assign f_wr_en[1]   = a_wr_en;
    assign f_wr_idx[1]  = a_wr_idx;
    assign f_wr_data[1] = a_wr_data;
    assign f_ra[1]      = a_rd_idx_a;
    assign f_rb[1]      = a_rd_idx_b;
    assign d_rd_data_a  = f_da[0];
    assign d_rd_data_b  = f_db[0];
    assign a_rd_data_a  = f_da[1];
    assign a_rd_data_b  = f_db[1];

    for (genvar f = 0; f < NFILES; f++) begin : g_file
        ctxrf_bank #(
            .DATA_W (DATA_W),
            .CTX_W  (CTX_W),
            .IDX_W  (IDX_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctx       (ctx_q),
            .wr_en     (f_wr_en[f]),
            .wr_idx    (f_wr_idx[f]),
            .wr_data   (f_wr_data[f]),
            .rd_idx_a  (f_ra[f]),
            .rd_idx_b  (f_rb[f]),
            .rd_data_a (f_da[f]),
            .rd_data_b (f_db[f])
        );
    end

    ctxrf_pcctx #(
        .CTX_W  (CTX_W),
        .OFFS_W (OFFS_W),
        .STEP_W (STEP_W)
    ) u_pcctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (pc_load_en),
        .ld_ctx   (pc_load_val[PC_W-2 -: CTX_W]),
        .ld_offs  (pc_load_val[OFFS_W-1:0]),
        .adv_en   (pc_adv_en),
        .adv_amt  (pc_adv_amt),
        .cset_en  (ctx_set_en),
        .cset_val (ctx_set_val),
        .ctx_q    (ctx_q),
        .offs_q   (offs)
    );

    ctxrf_fetch #(
        .OFFS_W    (OFFS_W),
        .CSEG_W    (CSEG_W),
        .SEG_SHIFT (SEG_SHIFT),
        .FETCH_W   (FETCH_W)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .seg_wr_en  (cseg_wr_en),
        .seg_wr_val (cseg_wr_val),
        .offs       (offs),
        .seg_q      (cseg_q),
        .fetch      (fetch_addr)
    );

    // Top bit unused; context mirrored below it
    assign pc_q = {1'b0, ctx_q, offs};

    // R7: the top bit of a loaded value never appears in the PC
    a_r7_top_bit_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_en |=> (pc_q[PC_W-1] == 1'b0) && (pc_q[PC_W-2:0] == $past(pc_load_val[PC_W-2:0])));

    // R5: a data write with no address write leaves address port A steady
    a_r5_files_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr_en && !a_wr_en && !pc_load_en && !ctx_set_en) ##1 (!a_wr_en && $stable(a_rd_idx_a))
        |-> $stable(a_rd_data_a));
endmodule

// File: tb/ctx_regfile_bench.sv
module ctx_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        d_wr_en = 0, a_wr_en = 0;
    logic [2:0]  d_wr_idx = 0, d_rd_idx_a = 0, d_rd_idx_b = 0;
    logic [2:0]  a_wr_idx = 0, a_rd_idx_a = 0, a_rd_idx_b = 0;
    logic [31:0] d_wr_data = 0, a_wr_data = 0;
    logic [31:0] d_rd_data_a, d_rd_data_b, a_rd_data_a, a_rd_data_b;
    logic        pc_load_en = 0, pc_adv_en = 0, ctx_set_en = 0, cseg_wr_en = 0;
    logic [31:0] pc_load_val = 0;
    logic [3:0]  pc_adv_amt = 0;
    logic [2:0]  ctx_set_val = 0;
    logic [27:0] cseg_wr_val = 0;
    logic [31:0] pc_q;
    logic [2:0]  ctx_q;
    logic [27:0] cseg_q;
    logic [39:0] fetch_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ctx_regfile u_ctx_regfile (
        .clk(clk), .rst_n(rst_n),
        .d_wr_en(d_wr_en), .d_wr_idx(d_wr_idx), .d_wr_data(d_wr_data),
        .d_rd_idx_a(d_rd_idx_a), .d_rd_idx_b(d_rd_idx_b),
        .d_rd_data_a(d_rd_data_a), .d_rd_data_b(d_rd_data_b),
        .a_wr_en(a_wr_en), .a_wr_idx(a_wr_idx), .a_wr_data(a_wr_data),
        .a_rd_idx_a(a_rd_idx_a), .a_rd_idx_b(a_rd_idx_b),
        .a_rd_data_a(a_rd_data_a), .a_rd_data_b(a_rd_data_b),
        .pc_load_en(pc_load_en), .pc_load_val(pc_load_val),
        .pc_adv_en(pc_adv_en), .pc_adv_amt(pc_adv_amt),
        .ctx_set_en(ctx_set_en), .ctx_set_val(ctx_set_val),
        .cseg_wr_en(cseg_wr_en), .cseg_wr_val(cseg_wr_val),
        .pc_q(pc_q), .ctx_q(ctx_q), .cseg_q(cseg_q), .fetch_addr(fetch_addr)
    );

    // {cseg[27:0], pc_in[31:0], exp_pc[31:0], exp_fetch[39:0]}
    localparam int NVEC = 5;
    localparam logic [131:0] VEC [NVEC] = '{
        {28'h0000000, 32'h0000_1234, 32'h0000_1234, 40'h00_0000_1234},
        {28'h0000001, 32'h0000_0000, 32'h0000_0000, 40'h00_0000_1000},
        {28'h0ABCDEF, 32'h1234_5678, 32'h1234_5678, 40'h0A_BF13_4678},
        {28'hFFFFFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 40'h00_0FFF_EFFF},
        {28'h0000000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 40'h00_0FFF_FFFF}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one rising edge; inputs changed at falling edges only
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_ctrl();
        d_wr_en = 0; a_wr_en = 0; pc_load_en = 0; pc_adv_en = 0;
        ctx_set_en = 0; cseg_wr_en = 0;
    endtask

    task automatic set_ctx(input logic [2:0] c);
        ctx_set_en = 1; ctx_set_val = c; tick(); clear_ctrl();
    endtask

    task automatic dwrite(input logic [2:0] idx, input logic [31:0] v);
        d_wr_en = 1; d_wr_idx = idx; d_wr_data = v; tick(); clear_ctrl();
    endtask

    task automatic awrite(input logic [2:0] idx, input logic [31:0] v);
        a_wr_en = 1; a_wr_idx = idx; a_wr_data = v; tick(); clear_ctrl();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pc", 64'(pc_q), 64'h0);
        chk("R1 ctx", 64'(ctx_q), 64'h0);
        chk("R1 cseg", 64'(cseg_q), 64'h0);
        chk("R1 fetch", 64'(fetch_addr), 64'h0);
        for (int c = 0; c < 8; c++) begin
            set_ctx(3'(c));
            for (int r = 0; r < 8; r++) begin
                d_rd_idx_a = 3'(r); a_rd_idx_b = 3'(r); #1;
                chk("R1 dreg", 64'(d_rd_data_a), 64'h0);
                chk("R1 areg", 64'(a_rd_data_b), 64'h0);
            end
        end

        // Vector table: R7 and R10 (and R11 on segment)
        for (int i = 0; i < NVEC; i++) begin
            cseg_wr_en = 1; cseg_wr_val = VEC[i][131:104];
            pc_load_en = 1; pc_load_val = VEC[i][103:72];
            tick(); clear_ctrl();
            chk("R11 cseg", 64'(cseg_q), 64'(VEC[i][131:104]));
            chk("R7 pc", 64'(pc_q), 64'(VEC[i][71:40]));
            chk("R6 ctx mirror", 64'(ctx_q), 64'(VEC[i][70:68]));
            chk("R10 fetch", 64'(fetch_addr), 64'(VEC[i][39:0]));
        end

        // R11: no write holds segment
        tick();
        chk("R11 hold", 64'(cseg_q), 64'h0);

        // R2: same index, different contexts
        set_ctx(3'd0);
        dwrite(3'd3, 32'hAAAA_0000);
        awrite(3'd3, 32'hA0A0_0003);
        set_ctx(3'd5);
        dwrite(3'd3, 32'hBBBB_5555);
        d_rd_idx_a = 3'd3; a_rd_idx_a = 3'd3; #1;
        chk("R2 ctx5 data", 64'(d_rd_data_a), 64'hBBBB_5555);
        chk("R2 ctx5 addr untouched", 64'(a_rd_data_a), 64'h0);
        set_ctx(3'd0); #1;
        chk("R2 ctx0 data", 64'(d_rd_data_a), 64'hAAAA_0000);
        chk("R5 ctx0 addr", 64'(a_rd_data_a), 64'hA0A0_0003);

        // R3: independent read ports
        dwrite(3'd6, 32'h6666_6666);
        d_rd_idx_a = 3'd6; d_rd_idx_b = 3'd3; #1;
        chk("R3 port a", 64'(d_rd_data_a), 64'h6666_6666);
        chk("R3 port b", 64'(d_rd_data_b), 64'hAAAA_0000);

        // R5: data write leaves address file alone
        dwrite(3'd3, 32'h1357_9BDF);
        a_rd_idx_b = 3'd3; #1;
        chk("R5 addr after data write", 64'(a_rd_data_b), 64'hA0A0_0003);

        // R4: same-cycle bypass, port B on another index keeps old value
        d_wr_en = 1; d_wr_idx = 3'd2; d_wr_data = 32'hFEED_2222;
        d_rd_idx_a = 3'd2; d_rd_idx_b = 3'd6; #1;
        chk("R4 bypass", 64'(d_rd_data_a), 64'hFEED_2222);
        chk("R4 other port", 64'(d_rd_data_b), 64'h6666_6666);
        tick(); clear_ctrl(); #1;
        chk("R4 after write", 64'(d_rd_data_a), 64'hFEED_2222);

        // R8: offset wrap does not carry into context
        pc_load_en = 1; pc_load_val = 32'h2FFF_FFFE; tick(); clear_ctrl();
        pc_adv_en = 1; pc_adv_amt = 4'd4; tick(); clear_ctrl();
        chk("R8 wrap pc", 64'(pc_q), 64'h2000_0002);
        chk("R8 wrap ctx", 64'(ctx_q), 64'h2);

        // R9: context set alone keeps offset
        set_ctx(3'd6);
        chk("R9 cset pc", 64'(pc_q), 64'h6000_0002);
        // R9: set plus advance
        ctx_set_en = 1; ctx_set_val = 3'd1; pc_adv_en = 1; pc_adv_amt = 4'd8;
        tick(); clear_ctrl();
        chk("R9 cset+adv", 64'(pc_q), 64'h1000_000A);
        // R9: load wins over set and advance
        pc_load_en = 1; pc_load_val = 32'h4000_0100;
        ctx_set_en = 1; ctx_set_val = 3'd7; pc_adv_en = 1; pc_adv_amt = 4'd2;
        tick(); clear_ctrl();
        chk("R9 load priority", 64'(pc_q), 64'h4000_0100);
        chk("R10 fetch no ctx", 64'(fetch_addr), 64'h00_0000_0100);

        // R2: register in ctx 4 read after PC load switches context
        dwrite(3'd1, 32'h4444_1111);
        pc_load_en = 1; pc_load_val = 32'h0000_0000; tick(); clear_ctrl();
        d_rd_idx_a = 3'd1; #1;
        chk("R2 ctx switch via pc", 64'(d_rd_data_a), 64'h0);
        pc_load_en = 1; pc_load_val = 32'hC000_0000; tick(); clear_ctrl(); #1;
        chk("R2 ctx restore via pc", 64'(d_rd_data_a), 64'h4444_1111);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule